// File: doc/BRIEF.md
# Logarithmic-depth multiplexer chain evaluator

The block computes every stage output of a chain of two-input multiplexers. Stage 0 takes an external seed as its select. Every later stage takes the output of the stage before it as its select. Each stage has its own pair of data bits: `a[i]` is chosen when the select is 0, and `b[i]` is chosen when the select is 1. So stage `i` computes `y[i] = sel ? b[i] : a[i]`.

The block does not let the select ripple through all N stages. It classifies each stage as one of four transforms of its select:

- force-0, when both bits are 0;
- force-1, when both bits are 1;
- pass, when `a=0`, `b=1`;
- flip, when `a=1`, `b=0`.

Composing two transforms gives another transform, and the composition is associative. A prefix network of ceil(log2 N) levels therefore gives, for each stage, the net transform of stages 0..i. That net transform is then applied to the seed. Every stage may carry a different setting.

An optional output register, selected by a parameter, adds one cycle of latency.

Top module: `pmux_chain`

## Requirements
- R1: A stage with `a[i]=0, b[i]=0` drives `y[i]=0` whatever its select.
- R2: A stage with `a[i]=1, b[i]=1` drives `y[i]=1` whatever its select.
- R3: A stage with `a[i]=0, b[i]=1` drives `y[i]` equal to its select.
- R4: A stage with `a[i]=1, b[i]=0` drives `y[i]` equal to the inverse of its select.
- R5: The select of stage 0 is `seed`, so `y[0] = seed ? b[0] : a[0]`.
- R6: For every `i>0`, the select of stage `i` is the stage-`(i-1)` output, so `y[i] = y[i-1] ? b[i] : a[i]`. Bit `i` of `a`, `b` and `y` belongs to stage `i`, and each stage may use a different setting.
- R7: With `OUT_REG=1` (the default), `y` shows the result for the inputs present at the previous rising clock edge. With `OUT_REG=0`, `y` is combinational.
- R8: While `rst_n` is low and `OUT_REG=1`, `y` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| seed | input | 1 | Select of stage 0 |
| a | input | N | Per-stage bit chosen when the select is 0 |
| b | input | N | Per-stage bit chosen when the select is 1 |
| y | output | N | Output of every stage |

## Verification
On every clock, the assertions compare the prefix network's combinational result against a single-stage ripple relation for each stage. They also check the four transform classes and that the registered output follows one cycle later. Only the bench's scenarios can show that whole chains come out right from end to end. Those scenarios are an exhaustive sweep of a four-stage chain, random sixteen-stage chains, and long pass and flip runs where one wrong composition would corrupt every later stage. Only the bench can show the reset value and the exact cycle of latency at the ports.

// File: rtl/pmux_chain.sv
`timescale 1ns/1ps
module pmux_chain #(
  parameter int N = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] y
);
  localparam int LV = (N > 1) ? $clog2(N) : 1;

  // code = {value when select is 1, value when select is 0}
  function automatic logic [1:0] compose(input logic [1:0] early, input logic [1:0] late);
    compose = {early[1] ? late[1] : late[0], early[0] ? late[1] : late[0]};
  endfunction

  logic [1:0] pf [0:LV][0:N-1];
  logic [N-1:0] y_c;

  for (genvar i = 0; i < N; i++) begin : g_enc
    assign pf[0][i] = {b[i], a[i]};
  end

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    for (genvar i = 0; i < N; i++) begin : g_cell
      if (i >= (1 << l)) begin : g_op
        assign pf[l+1][i] = compose(pf[l][i-(1<<l)], pf[l][i]);
      end else begin : g_pass
        assign pf[l+1][i] = pf[l][i];
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    assign y_c[i] = seed ? pf[LV][i][1] : pf[LV][i][0];
  end

  if (OUT_REG) begin : g_reg
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        y     <= '0;
        armed <= 1'b0;
      end else begin
        y     <= y_c;
        armed <= 1'b1;
      end
    end
    a_r7_reg_follows: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> y == $past(y_c));
  end else begin : g_comb
    assign y = y_c;
  end

  a_r5_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
    y_c[0] == (seed ? b[0] : a[0]));

  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r1_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (!a[i] && !b[i]) |-> !y_c[i]);
    a_r2_gen: assert property (@(posedge clk) disable iff (!rst_n)
      (a[i] && b[i]) |-> y_c[i]);
    if (i > 0) begin : g_link
      a_r6_ripple: assert property (@(posedge clk) disable iff (!rst_n)
        y_c[i] == (y_c[i-1] ? b[i] : a[i]));
      a_r3_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        (!a[i] && b[i]) |-> y_c[i] == y_c[i-1]);
      a_r4_invert: assert property (@(posedge clk) disable iff (!rst_n)
        (a[i] && !b[i]) |-> y_c[i] != y_c[i-1]);
    end
  end
endmodule

// File: tb/test_pmux_chain.sv
`timescale 1ns/1ps
module test_pmux_chain;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seed, seed4;
  logic [15:0] a, b, y;
  logic [3:0] a4, b4, y4;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  pmux_chain #(.N(16), .OUT_REG(1'b1)) i_pmux_chain (
    .clk(clk), .rst_n(rst_n), .seed(seed), .a(a), .b(b), .y(y));
  pmux_chain #(.N(4), .OUT_REG(1'b0)) i_pmux_chain_small (
    .clk(clk), .rst_n(rst_n), .seed(seed4), .a(a4), .b(b4), .y(y4));

  function automatic logic [15:0] ripple(input int n, input logic s,
                                         input logic [15:0] va, input logic [15:0] vb);
    logic sel = s;
    logic [15:0] r = '0;
    for (int i = 0; i < n; i++) begin
      r[i] = sel ? vb[i] : va[i];
      sel = r[i];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic run16(input string req, input logic s, input logic [15:0] va, input logic [15:0] vb);
    @(negedge clk);
    seed = s; a = va; b = vb;
    @(negedge clk);
    check(req, y, ripple(16, s, va, vb));
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: got=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] prev;
    seed = 1'b1; a = 16'hFFFF; b = 16'hFFFF;
    seed4 = 1'b0; a4 = '0; b4 = '0;
    repeat (3) @(negedge clk);
    check("R8", y, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    run16("R1", 1'b1, 16'h0000, 16'h0000);
    run16("R2", 1'b0, 16'hFFFF, 16'hFFFF);
    run16("R3", 1'b1, 16'h0000, 16'hFFFF);
    check("R3", y, 16'hFFFF);
    run16("R3", 1'b0, 16'h0000, 16'hFFFF);
    check("R3", y, 16'h0000);
    run16("R4", 1'b1, 16'hFFFF, 16'h0000);
    check("R4", y, 16'hAAAA);
    run16("R4", 1'b0, 16'hFFFF, 16'h0000);
    check("R4", y, 16'h5555);
    // buffer chain broken by one stop in the middle, seed 1
    run16("R1", 1'b1, 16'h0000, 16'hFEFF);
    check("R1", y, 16'h00FF);
    // first stage flip, rest buffer
    run16("R5", 1'b0, 16'h0001, 16'hFFFE);
    check("R5", y, 16'hFFFF);
    run16("R5", 1'b1, 16'h0002, 16'h0001);
    check("R5", y[0], 16'h0001);

    // R7: output holds until the next rising edge
    @(negedge clk);
    prev = y;
    seed = 1'b1; a = 16'h0000; b = 16'hFFFF;
    #1 check("R7", y, prev);
    @(negedge clk);
    check("R7", y, 16'hFFFF);

    for (int k = 0; k < 3000; k++) begin
      logic [15:0] ra = 16'($urandom);
      logic [15:0] rb = 16'($urandom);
      run16("R6", 1'($urandom), ra, rb);
    end

    // exhaustive four-stage combinational sweep
    for (int v = 0; v < 512; v++) begin
      @(negedge clk);
      seed4 = v[8]; a4 = v[3:0]; b4 = v[7:4];
      #1 check("R6", {12'h0, y4}, ripple(4, v[8], {12'h0, v[3:0]}, {12'h0, v[7:4]}));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule